// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Controller

This block keeps a DRAM array with a 4096-row refresh need alive. Once the array is up, it issues CAS-before-RAS refresh cycles on a fixed cadence. At power-up it also brings the array into service. After reset it waits at least 200 µs. It then runs eight warm-up refresh cycles back to back, and only after that does it raise `init_done`. The access sequencer must not start any access while `init_done` is low. During initialisation the controller owns the strobes and needs no grant.

In normal operation an interval timer fires once every 64 ms / 4096, rounded down to whole clock cycles. Each firing adds one owed refresh to a backlog that saturates at four. While refreshes are owed, the controller holds `refresh_req`. When the sequencer answers with `refresh_gnt`, the controller drives RAS, CAS and WE directly and clears the whole backlog in one burst. The DRAM's internal row counter picks the row, so no address is produced. Every strobe timing is written in nanoseconds and turned into clock cycles from the `CLK_PERIOD_NS` parameter.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, and `refresh_req` and `init_done` are 0.
- R2: The strobes stay inactive (1) during the power-up pause. The first warm-up refresh drives `cas_n` low exactly INIT_CYC+2 cycles after reset is released, where INIT_CYC = ceil(200 µs / clock period) and the 2 cycles come from reset synchronisation.
- R3: Eight warm-up refreshes follow back to back with no grant needed. `init_done` rises in the cycle after the eighth precharge ends and then stays high. `refresh_req` stays low while `init_done` is low.
- R4: In every refresh, `cas_n` falls ceil(10 ns / period) cycles before `ras_n` falls. `ras_n` stays low for ceil(50 ns / period) cycles. `cas_n` stays low for the whole time `ras_n` is low and rises in the same cycle as `ras_n`.
- R5: `we_n` is 1 at all times.
- R6: Between consecutive refreshes, `ras_n` is high for at least ceil(30 ns / period) cycles. Successive `cas_n` falls are at least ceil(90 ns / period) cycles apart.
- R7: The first `refresh_req` rises INTERVAL_CYC+1 cycles after `init_done` rises, and later requests follow every INTERVAL_CYC cycles, where INTERVAL_CYC = floor(64 ms / 4096 / period).
- R8: While `refresh_req` is 1 and `refresh_gnt` is 0, the strobes do not move. `cas_n` falls in the cycle after a grant is sampled.
- R9: Owed refreshes accumulate up to 4, and further intervals are dropped. On grant, all owed refreshes run back to back. `refresh_req` stays high through the burst and falls in the cycle after the last precharge, with nothing left owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| refresh_gnt | input | 1 | Sequencer grants the DRAM strobes to this block |
| refresh_req | output | 1 | Refresh owed; held until the burst completes |
| init_done | output | 1 | Power-up pause and eight warm-up refreshes finished |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low, kept high |

## Verification
With the default 10 ns clock, the first CAS fall is due 20002 cycles after reset release, and `init_done` is due 72 cycles later. The first request is due 1563 cycles after `init_done`. A granted refresh shows CAS low one cycle after the grant, RAS low one cycle later, RAS high again after five more cycles, and the request drops nine cycles per refresh after the first CAS fall. The bench derives each of these cycle numbers from the nanosecond rules on its own. Before each grant or warm-up phase it queues the expected CAS-fall cycle. A monitor sampling on the falling clock edge pops one queue entry for each refresh it sees and measures the strobe spacing. Level checks are made at the named cycle and at the cycle just before it, so an early or late change is caught.

// File: rtl/dref_pkg.sv
package dref_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_REQ   = 3'd2,
    ST_CASLO = 3'd3,
    ST_RASLO = 3'd4,
    ST_PRECH = 3'd5
  } dref_state_e;

  // whole clock cycles covering a nanosecond span, never fewer than one
  function automatic int ns_to_cyc(input int span_ns, input int period_ns);
    int c;
    c = (span_ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dref_rst_sync.sv
module dref_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dref_interval.sv
module dref_interval #(
  parameter int PERIOD_CYC = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (enable) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = enable && (cnt_q == LAST);
endmodule

// File: rtl/dref_backlog.sv
module dref_backlog #(
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic [$clog2(MAX_OWED+1)-1:0] owed,
  output logic pending
);
  localparam int BW = $clog2(MAX_OWED + 1);
  localparam logic [BW-1:0] CAP = BW'(MAX_OWED);

  logic [BW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    if (add && !take) begin
      if (owed_q != CAP) owed_d = owed_q + 1'b1;
    end else if (take && !add) begin
      if (owed_q != '0) owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  assign owed    = owed_q;
  assign pending = (owed_q != '0);
endmodule

// File: rtl/dref_fsm.sv
module dref_fsm
  import dref_pkg::*;
#(
  parameter int PWRUP_CYC = 20000,
  parameter int SETUP_CYC = 1,
  parameter int STROBE_CYC = 5,
  parameter int PRECH_CYC = 3,
  parameter int WARMUP_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic gnt,
  output logic start,
  output logic ready,
  output logic req,
  output logic ras_n,
  output logic cas_n
);
  localparam int TW = $clog2(max_int(max_int(PWRUP_CYC, STROBE_CYC),
                                     max_int(SETUP_CYC, PRECH_CYC)) + 1);
  localparam int WW = (WARMUP_N > 1) ? $clog2(WARMUP_N) : 1;
  localparam logic [TW-1:0] PWRUP_LD  = TW'(PWRUP_CYC - 1);
  localparam logic [TW-1:0] SETUP_LD  = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] STROBE_LD = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] PRECH_LD  = TW'(PRECH_CYC - 1);
  localparam logic [WW-1:0] WARM_LAST = WW'(WARMUP_N - 1);

  dref_state_e   st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [WW-1:0] warm_q, warm_d;
  logic          rdy_q, rdy_d;
  logic          tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    warm_d = warm_q;
    rdy_d  = rdy_q;
    start  = 1'b0;
    unique case (st_q)
      ST_PWRUP: begin
        if (tmr_zero) begin
          st_d  = ST_CASLO;
          tmr_d = SETUP_LD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_IDLE: begin
        if (pending) st_d = ST_REQ;
      end
      ST_REQ: begin
        if (gnt) begin
          st_d  = ST_CASLO;
          tmr_d = SETUP_LD;
          start = 1'b1;
        end
      end
      ST_CASLO: begin
        if (tmr_zero) begin
          st_d  = ST_RASLO;
          tmr_d = STROBE_LD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_RASLO: begin
        if (tmr_zero) begin
          st_d  = ST_PRECH;
          tmr_d = PRECH_LD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_PRECH: begin
        if (!tmr_zero) begin
          tmr_d = tmr_q - 1'b1;
        end else if (!rdy_q) begin
          if (warm_q == WARM_LAST) begin
            rdy_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            warm_d = warm_q + 1'b1;
            st_d   = ST_CASLO;
            tmr_d  = SETUP_LD;
          end
        end else if (pending) begin
          st_d  = ST_CASLO;
          tmr_d = SETUP_LD;
          start = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PWRUP;
      tmr_q  <= PWRUP_LD;
      warm_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      warm_q <= warm_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ready = rdy_q;
  assign cas_n = !((st_q == ST_CASLO) || (st_q == ST_RASLO));
  assign ras_n = !(st_q == ST_RASLO);
  assign req   = (st_q == ST_REQ) ||
                 (rdy_q && ((st_q == ST_CASLO) || (st_q == ST_RASLO) || (st_q == ST_PRECH)));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dref_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ROWS = 4096,
  parameter int WINDOW_US = 64000,
  parameter int PWRUP_US = 200,
  parameter int WARMUP_N = 8,
  parameter int MAX_OWED = 4,
  parameter int CAS_SETUP_NS = 10,
  parameter int CAS_HOLD_NS = 8,
  parameter int RAS_WIDTH_NS = 50,
  parameter int RAS_PRECH_NS = 30,
  parameter int CYCLE_NS = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_gnt,
  output logic refresh_req,
  output logic init_done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int SETUP_CYC  = ns_to_cyc(CAS_SETUP_NS, CLK_PERIOD_NS);
  localparam int STROBE_CYC = ns_to_cyc(max_int(RAS_WIDTH_NS, CAS_HOLD_NS), CLK_PERIOD_NS);
  localparam int CYCLE_CYC  = ns_to_cyc(CYCLE_NS, CLK_PERIOD_NS);
  localparam int PRECH_CYC  = max_int(ns_to_cyc(RAS_PRECH_NS, CLK_PERIOD_NS),
                                      CYCLE_CYC - SETUP_CYC - STROBE_CYC);
  localparam int PWRUP_CYC  = ns_to_cyc(PWRUP_US * 1000, CLK_PERIOD_NS);
  localparam int INTERVAL_CYC = (WINDOW_US * 1000) / (ROWS * CLK_PERIOD_NS);
  localparam int BW = $clog2(MAX_OWED + 1);

  logic          rst_int_n;
  logic          tick, start, pending, ready;
  logic [BW-1:0] owed;

  dref_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dref_interval #(.PERIOD_CYC(INTERVAL_CYC)) u_interval (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .enable (ready),
    .tick   (tick)
  );

  dref_backlog #(.MAX_OWED(MAX_OWED)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .add     (tick),
    .take    (start),
    .owed    (owed),
    .pending (pending)
  );

  dref_fsm #(
    .PWRUP_CYC  (PWRUP_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .PRECH_CYC  (PRECH_CYC),
    .WARMUP_N   (WARMUP_N)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pending (pending),
    .gnt     (refresh_gnt),
    .start   (start),
    .ready   (ready),
    .req     (refresh_req),
    .ras_n   (ras_n),
    .cas_n   (cas_n)
  );

  assign init_done = ready;
  // refresh is CAS-before-RAS only, so the write strobe never leaves high
  assign we_n = 1'b1;
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int MAX_OWED = 4
) (
  input logic clk,
  input logic rst_n,
  input logic refresh_gnt,
  input logic refresh_req,
  input logic init_done,
  input logic ras_n,
  input logic cas_n,
  input logic [$clog2(MAX_OWED+1)-1:0] owed
);
  // R4
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R4
  cas_covers_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R3
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R3
  no_req_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_req);

  // R8
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && refresh_req && !refresh_gnt && cas_n) |=> cas_n);

  // R8
  gnt_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && init_done) |-> $past(refresh_gnt));

  // R9
  owed_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= ($clog2(MAX_OWED+1))'(MAX_OWED));
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.MAX_OWED(MAX_OWED)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_gnt (refresh_gnt),
  .refresh_req (refresh_req),
  .init_done   (init_done),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .owed        (owed)
);

// File: tb/tb_dram_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_dram_refresh_ctrl;
  localparam int CLK_NS   = 10;
  localparam int T_SETUP  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int T_STROBE = (50 + CLK_NS - 1) / CLK_NS;
  localparam int T_PRE_MIN = (30 + CLK_NS - 1) / CLK_NS;
  localparam int T_CYC_MIN = (90 + CLK_NS - 1) / CLK_NS;
  localparam int T_CYC    = 9;        // setup + strobe + precharge at 10 ns
  localparam int T_INIT   = (200000 + CLK_NS - 1) / CLK_NS;
  localparam int T_IVL    = 64000000 / (4096 * CLK_NS);
  localparam int WATCHDOG = 60000;

  logic clk, rst_n, refresh_gnt;
  logic refresh_req, init_done, ras_n, cas_n, we_n;

  int n_chk, n_fail, cyc;
  int exp_q[$];
  bit mon_en, we_bad, done;
  logic prev_cas, prev_ras;
  int cas_fall_c, ras_fall_c, ras_rise_c;

  dram_refresh_ctrl #(.CLK_PERIOD_NS(CLK_NS)) dut (
    .clk (clk), .rst_n (rst_n), .refresh_gnt (refresh_gnt),
    .refresh_req (refresh_req), .init_done (init_done),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // scoreboard driver: queue the expected CAS-fall cycles of a run of refreshes
  task automatic expect_burst(input int first, input int count);
    for (int k = 0; k < count; k++) exp_q.push_back(first + k * T_CYC);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (!we_n) we_bad = 1'b1;
      if (prev_cas && !cas_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected refresh", cyc, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R8 refresh start cycle", cyc, e);
        end
        chk(ras_n == 1'b1, "R4 RAS high at CAS fall", int'(ras_n), 1);
        if (ras_rise_c >= 0) begin
          chk(cyc - ras_rise_c >= T_PRE_MIN, "R6 precharge", cyc - ras_rise_c, T_PRE_MIN);
          chk(cyc - cas_fall_c >= T_CYC_MIN, "R6 cycle time", cyc - cas_fall_c, T_CYC_MIN);
        end
        cas_fall_c = cyc;
      end
      if (prev_ras && !ras_n) begin
        chk(cyc - cas_fall_c == T_SETUP && !cas_n, "R4 CAS lead", cyc - cas_fall_c, T_SETUP);
        ras_fall_c = cyc;
      end
      if (!prev_ras && ras_n) begin
        chk(cyc - ras_fall_c == T_STROBE, "R4 RAS width", cyc - ras_fall_c, T_STROBE);
        chk(cas_n == 1'b1, "R4 CAS rises with RAS", int'(cas_n), 1);
        ras_rise_c = cyc;
      end
      prev_cas = cas_n;
      prev_ras = ras_n;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, g;
    n_chk = 0; n_fail = 0; mon_en = 0; we_bad = 0; done = 0;
    prev_cas = 1'b1; prev_ras = 1'b1;
    cas_fall_c = -1; ras_fall_c = -1; ras_rise_c = -1;
    rst_n = 1'b0; refresh_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!refresh_req && !init_done, "R1 req/init low in reset", {refresh_req, init_done}, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    expect_burst(T_INIT + 2, 8);

    // R2 nothing moves during the pause
    wait_cyc(T_INIT + 1);
    chk(ras_n && cas_n, "R2 strobes idle before pause ends", {ras_n, cas_n}, 3);
    wait_cyc(T_INIT + 2);
    chk(!cas_n, "R2 first warm-up CAS", int'(cas_n), 0);

    // R3 warm-up ends without any grant
    wait_cyc(T_INIT + 2 + 8 * T_CYC - 1);
    chk(!init_done, "R3 init_done before 8th refresh ends", int'(init_done), 0);
    wait_cyc(T_INIT + 2 + 8 * T_CYC);
    chk(init_done, "R3 init_done after warm-up", int'(init_done), 1);
    chk(exp_q.size() == 0, "R3 eight warm-up refreshes", 8 - exp_q.size(), 8);
    c0 = cyc;

    // R7 first request
    wait_cyc(c0 + T_IVL);
    chk(!refresh_req, "R7 no request before interval", int'(refresh_req), 0);
    wait_cyc(c0 + T_IVL + 1);
    chk(refresh_req, "R7 request after interval", int'(refresh_req), 1);
    // R8 hold off the grant and watch the strobes
    wait_cyc(c0 + T_IVL + 6);
    chk(ras_n && cas_n && refresh_req, "R8 idle while not granted", {ras_n, cas_n, refresh_req}, 7);
    g = cyc;
    refresh_gnt = 1'b1;
    expect_burst(g + 1, 1);
    wait_cyc(g + T_CYC);
    chk(refresh_req, "R9 request held through refresh", int'(refresh_req), 1);
    wait_cyc(g + T_CYC + 1);
    chk(!refresh_req, "R9 request drops after single refresh", int'(refresh_req), 0);
    refresh_gnt = 1'b0;

    // R7 second request on the cadence, granted at once
    wait_cyc(c0 + 2 * T_IVL);
    chk(!refresh_req, "R7 second request not early", int'(refresh_req), 0);
    wait_cyc(c0 + 2 * T_IVL + 1);
    chk(refresh_req, "R7 second request on time", int'(refresh_req), 1);
    g = cyc;
    refresh_gnt = 1'b1;
    expect_burst(g + 1, 1);
    wait_cyc(g + T_CYC + 1);
    chk(!refresh_req, "R9 request drops after second refresh", int'(refresh_req), 0);
    refresh_gnt = 1'b0;

    // R9 six intervals without grant: backlog saturates at four
    wait_cyc(c0 + 8 * T_IVL + 100);
    chk(ras_n && cas_n && refresh_req, "R8 idle through long wait", {ras_n, cas_n, refresh_req}, 7);
    g = cyc;
    refresh_gnt = 1'b1;
    expect_burst(g + 1, 4);
    wait_cyc(g + 4 * T_CYC);
    chk(refresh_req, "R9 request held through burst", int'(refresh_req), 1);
    wait_cyc(g + 4 * T_CYC + 1);
    chk(!refresh_req, "R9 burst of exactly four", int'(refresh_req), 0);
    refresh_gnt = 1'b0;
    chk(exp_q.size() == 0, "R9 all burst refreshes seen", exp_q.size(), 0);

    // R9 nothing left owed: next request only on the ninth interval
    wait_cyc(c0 + 9 * T_IVL);
    chk(!refresh_req, "R9 no leftover request", int'(refresh_req), 0);
    wait_cyc(c0 + 9 * T_IVL + 1);
    chk(refresh_req, "R7 request on ninth interval", int'(refresh_req), 1);
    g = cyc;
    refresh_gnt = 1'b1;
    expect_burst(g + 1, 1);
    wait_cyc(g + T_CYC + 1);
    chk(!refresh_req, "R9 single refresh after burst", int'(refresh_req), 0);
    refresh_gnt = 1'b0;
    wait_cyc(g + T_CYC + 20);

    chk(exp_q.size() == 0, "R8 every expected refresh seen", exp_q.size(), 0);
    chk(!we_bad, "R5 WE never low", int'(we_bad), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule